// File: doc/BRIEF.md
# Windowed Event Counter

This block counts qualified events from an upstream event decoder and turns the count into a gated output level. The level rises when the count reaches a programmable switch-on value and falls when it reaches a programmable switch-off value. Between those two points it forms a window in event space, for example a run of lines on a conveyor that an encoder measures.

Counting starts only after a start condition is met while the count sits at zero. The start can be disabled, immediate, or triggered by the rising edge of one of two internal trigger lines. Three policies control what happens at the top of the range: hold at the maximum, wrap around automatically, or clear on the rising edge of a selected trigger line. In encoder mode, events flagged as reverse direction count down, and the count never goes below zero. The count is available for readback, and a clearing strobe empties it in the cycle after it is read. A change to the maximum, the start setting or the reset setting empties the count and disarms the block.

Top module: `windowed_event_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `count_o` becomes 0 and `level_o` becomes 0.
- R2: Start modes: a start code of 0 never arms, 1 arms, and 2 arms on a rising edge of `trig_i[cfg_start_sel_i]`. The block arms only while the count is 0 and it is disarmed. Arming takes one clock edge, and an event at that edge is not counted.
- R3: While the block is armed, each forward event raises `count_o` by one at the next edge. When `enc_mode_i` is 0, every event is forward, whatever the value of `evt_rev_i`.
- R4: When `enc_mode_i` is 1 and `evt_rev_i` is 1, an event lowers the count by one. At 0 the count stays at 0 and the block stays armed.
- R5: With reset code 0 (hold), forward events at the maximum leave the count at the maximum, and the count never exceeds `cfg_max_i`.
- R6: With reset code 1 (auto), a forward event at the maximum sets the count to 0 and disarms the block. The start condition must then be met again before counting resumes.
- R7: With reset code 2 (edge), a rising edge of `trig_i[cfg_reset_sel_i]` sets the count to 0 and disarms the block, at any count, and takes priority over an event in the same cycle.
- R8: `level_o` goes to 1 one edge after `count_o` equals `cfg_on_i`, and to 0 one edge after it equals `cfg_off_i`. When both match, 1 wins. Otherwise the level holds.
- R9: A change to `cfg_max_i`, the start code or selector, or the reset code or selector sets the count to 0 and disarms the block at that edge. A change to `cfg_on_i` or `cfg_off_i` does not.
- R10: `rd_clr_i` high at an edge clears the count to 0 and disarms the block. `count_o` in that cycle holds the value being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | One-cycle event strobe |
| evt_rev_i | input | 1 | Event is in the reverse direction |
| enc_mode_i | input | 1 | Encoder mode: reverse events count down |
| trig_i | input | 2 | Internal trigger lines for start and reset |
| cfg_max_i | input | CNT_W | Maximum count |
| cfg_on_i | input | CNT_W | Count that sets the level |
| cfg_off_i | input | CNT_W | Count that clears the level |
| cfg_start_i | input | 2 | Start code: 0 off, 1 on, 2 trigger edge |
| cfg_start_sel_i | input | 1 | Trigger line used by the start condition |
| cfg_reset_i | input | 2 | Reset code: 0 hold, 1 auto wrap, 2 trigger edge |
| cfg_reset_sel_i | input | 1 | Trigger line used by the reset edge |
| rd_clr_i | input | 1 | Clear the count after this read |
| level_o | output | 1 | Window output level |
| count_o | output | CNT_W | Current count |

## Verification
The hardest state to reach from the ports is a disarmed block at count zero that is then offered events. It occurs after an auto wrap, a clearing read or a configuration change, and there an event must be silently dropped for exactly one cycle. The stimulus reaches this state by driving an event on the very edge that wraps or clears and on the edge after it, then checking that the count is still zero before the third event finally counts. Underflow is approached the same way: reverse events are driven at count zero in encoder mode, followed by a forward event that must count at once, which shows the block stayed armed.

// File: rtl/wec_pkg.sv
package wec_pkg;
    localparam int NTRIG = 2;
    localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_EDGE = 2'd2
    } start_e;

    typedef enum logic [1:0] {
        RM_HOLD = 2'd0,
        RM_AUTO = 2'd1,
        RM_EDGE = 2'd2
    } rmode_e;

    typedef struct packed {
        start_e             smode;
        logic [SEL_W-1:0]   ssel;
        rmode_e             rmode;
        logic [SEL_W-1:0]   rsel;
    } mode_t;

    function automatic logic pick(input logic [NTRIG-1:0] v, input logic [SEL_W-1:0] s);
        return v[s];
    endfunction
endpackage

// File: rtl/wec_rise.sv
module wec_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/wec_cfg_watch.sv
module wec_cfg_watch
    import wec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic [CNT_W-1:0] max_i,
    input  mode_t            mode_i,
    output logic [CNT_W-1:0] max_q,
    output mode_t            mode_q,
    output logic             chg_o
);
    always_ff @(posedge clk) begin
        max_q  <= max_i;
        mode_q <= mode_i;
    end

    assign chg_o = (max_i != max_q) || (mode_i != mode_q);
endmodule

// File: rtl/wec_core.sv
module wec_core
    import wec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             fwd_i,
    input  logic [CNT_W-1:0] max_i,
    input  mode_t            mode_i,
    input  logic [NTRIG-1:0] rise_i,
    input  logic             chg_i,
    input  logic             rdclr_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic armed_q;
    logic start_ok;
    logic rst_edge;
    logic clr_any;
    logic at_max;
    logic at_zero;

    always_comb begin
        unique case (mode_i.smode)
            ST_ON:   start_ok = 1'b1;
            ST_EDGE: start_ok = pick(rise_i, mode_i.ssel);
            default: start_ok = 1'b0;
        endcase
    end

    assign rst_edge = (mode_i.rmode == RM_EDGE) && pick(rise_i, mode_i.rsel);
    assign clr_any  = chg_i || rdclr_i || rst_edge;
    assign at_max   = (count_o == max_i);
    assign at_zero  = (count_o == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
            armed_q <= 1'b0;
        end else if (clr_any) begin
            count_o <= '0;
            armed_q <= 1'b0;
        end else if (!armed_q) begin
            if (at_zero && start_ok) armed_q <= 1'b1;
        end else if (evt_i) begin
            if (fwd_i) begin
                if (!at_max) begin
                    count_o <= count_o + ONE;
                end else if (mode_i.rmode == RM_AUTO) begin
                    count_o <= '0;
                    armed_q <= 1'b0;
                end
            end else if (!at_zero) begin
                count_o <= count_o - ONE;
            end
        end
    end

    p_cnt_le_max_r5: assert property (@(posedge clk) disable iff (rst)
        count_o <= max_i);

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_i && !fwd_i && at_zero && !clr_any) |=> (count_o == '0));

    p_hold_at_max_r5: assert property (@(posedge clk) disable iff (rst)
        (armed_q && evt_i && fwd_i && at_max && !clr_any && mode_i.rmode == RM_HOLD)
        |=> $stable(count_o));

    p_auto_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (armed_q && evt_i && fwd_i && at_max && !clr_any && mode_i.rmode == RM_AUTO)
        |=> (count_o == '0));

    p_reset_edge_r7: assert property (@(posedge clk) disable iff (rst)
        rst_edge |=> (count_o == '0));
endmodule

// File: rtl/wec_level.sv
module wec_level #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] on_i,
    input  logic [CNT_W-1:0] off_i,
    output logic             level_o
);
    always_ff @(posedge clk) begin
        if (rst)                    level_o <= 1'b0;
        else if (count_i == on_i)   level_o <= 1'b1;
        else if (count_i == off_i)  level_o <= 1'b0;
    end

    p_on_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (count_i == on_i) |=> level_o);

    p_off_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (count_i == off_i && count_i != on_i) |=> !level_o);
endmodule

// File: rtl/windowed_event_counter.sv
module windowed_event_counter
    import wec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_i,
    input  logic             evt_rev_i,
    input  logic             enc_mode_i,
    input  logic [1:0]       trig_i,
    input  logic [CNT_W-1:0] cfg_max_i,
    input  logic [CNT_W-1:0] cfg_on_i,
    input  logic [CNT_W-1:0] cfg_off_i,
    input  logic [1:0]       cfg_start_i,
    input  logic             cfg_start_sel_i,
    input  logic [1:0]       cfg_reset_i,
    input  logic             cfg_reset_sel_i,
    input  logic             rd_clr_i,
    output logic             level_o,
    output logic [CNT_W-1:0] count_o
);
    mode_t            mode_in;
    mode_t            mode_q;
    logic [CNT_W-1:0] max_q;
    logic             chg;
    logic [NTRIG-1:0] rise;
    logic             fwd;

    assign mode_in.smode = start_e'(cfg_start_i);
    assign mode_in.ssel  = cfg_start_sel_i;
    assign mode_in.rmode = rmode_e'(cfg_reset_i);
    assign mode_in.rsel  = cfg_reset_sel_i;
    assign fwd           = !(enc_mode_i && evt_rev_i);

    wec_rise #(.N(NTRIG)) rise_i (
        .clk(clk), .rst(rst), .sig_i(trig_i), .rise_o(rise)
    );

    wec_cfg_watch #(.CNT_W(CNT_W)) watch_i (
        .clk(clk), .max_i(cfg_max_i), .mode_i(mode_in),
        .max_q(max_q), .mode_q(mode_q), .chg_o(chg)
    );

    wec_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst(rst), .evt_i(evt_i), .fwd_i(fwd),
        .max_i(max_q), .mode_i(mode_q), .rise_i(rise),
        .chg_i(chg), .rdclr_i(rd_clr_i), .count_o(count_o)
    );

    wec_level #(.CNT_W(CNT_W)) level_i (
        .clk(clk), .rst(rst), .count_i(count_o),
        .on_i(cfg_on_i), .off_i(cfg_off_i), .level_o(level_o)
    );

    p_cfg_clear_r9: assert property (@(posedge clk) disable iff (rst)
        chg |=> (count_o == '0));

    p_rdclr_r10: assert property (@(posedge clk) disable iff (rst)
        rd_clr_i |=> (count_o == '0));
endmodule

// File: tb/windowed_event_counter_tb_top.sv
module windowed_event_counter_tb_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic             evt_i, evt_rev_i, enc_mode_i, rd_clr_i;
    logic [1:0]       trig_i;
    logic [CNT_W-1:0] cfg_max_i, cfg_on_i, cfg_off_i;
    logic [1:0]       cfg_start_i, cfg_reset_i;
    logic             cfg_start_sel_i, cfg_reset_sel_i;
    logic             level_o;
    logic [CNT_W-1:0] count_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    windowed_event_counter #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .evt_i(evt_i), .evt_rev_i(evt_rev_i),
        .enc_mode_i(enc_mode_i), .trig_i(trig_i), .cfg_max_i(cfg_max_i),
        .cfg_on_i(cfg_on_i), .cfg_off_i(cfg_off_i), .cfg_start_i(cfg_start_i),
        .cfg_start_sel_i(cfg_start_sel_i), .cfg_reset_i(cfg_reset_i),
        .cfg_reset_sel_i(cfg_reset_sel_i), .rd_clr_i(rd_clr_i),
        .level_o(level_o), .count_o(count_o)
    );

    // columns: evt, rev, rd_clr, expected count, expected level
    // max 5, on 3, off 5, start on, reset hold, encoder mode on
    localparam int NV = 17;
    localparam int VEC [NV][5] = '{
        '{1,0,0, 0,0},  // R2 arming edge drops the event
        '{1,0,0, 1,0},  // R3
        '{0,0,0, 1,0},
        '{1,0,0, 2,0},
        '{1,0,0, 3,0},
        '{0,0,0, 3,1},  // R8 level set one edge after count hits on
        '{1,1,0, 2,1},  // R4 reverse counts down
        '{1,0,0, 3,1},
        '{1,0,0, 4,1},
        '{1,0,0, 5,1},
        '{1,0,0, 5,0},  // R5 hold at max, R8 off clears
        '{0,0,1, 0,0},  // R10 clearing read
        '{1,0,0, 0,0},  // R10 disarmed: rearm edge drops the event
        '{1,0,0, 1,0},
        '{1,1,0, 0,0},  // R4
        '{1,1,0, 0,0},  // R4 no underflow
        '{1,0,0, 1,0}   // R4 stays armed at zero
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic r, input logic c);
        evt_i = e; evt_rev_i = r; rd_clr_i = c;
        @(posedge clk);
        #5;
        evt_i = 1'b0; evt_rev_i = 1'b0; rd_clr_i = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; evt_i = 0; evt_rev_i = 0; enc_mode_i = 1; rd_clr_i = 0;
        trig_i = 2'b00; cfg_max_i = 5; cfg_on_i = 3; cfg_off_i = 5;
        cfg_start_i = 2'd1; cfg_start_sel_i = 0; cfg_reset_i = 2'd0; cfg_reset_sel_i = 0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1 count", int'(count_o), 0);
        chk("R1 level", int'(level_o), 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][0][0], VEC[i][1][0], VEC[i][2][0]);
            chk($sformatf("R3 table row %0d count", i), int'(count_o), VEC[i][3]);
            chk($sformatf("R8 table row %0d level", i), int'(level_o), VEC[i][4]);
        end

        // R3: without encoder mode the reverse flag is ignored
        enc_mode_i = 0;
        step(1, 1, 0); chk("R3 rev ignored", int'(count_o), 2);

        // R6 auto wrap (mode change also clears: R9)
        cfg_reset_i = 2'd1;
        step(0, 0, 0); chk("R9 reset mode change clears", int'(count_o), 0);
        step(0, 0, 0);
        for (int k = 1; k <= 5; k++) step(1, 0, 0);
        chk("R6 reach max", int'(count_o), 5);
        step(1, 0, 0); chk("R6 wrap to zero", int'(count_o), 0);
        step(1, 0, 0); chk("R6 rearm drops event", int'(count_o), 0);
        step(1, 0, 0); chk("R6 resumes", int'(count_o), 1);

        // R2 start off
        cfg_start_i = 2'd0;
        step(0, 0, 0); chk("R9 start change clears", int'(count_o), 0);
        for (int k = 0; k < 3; k++) step(1, 0, 0);
        chk("R2 start off idle", int'(count_o), 0);

        // R2 start on trigger line 1
        cfg_start_i = 2'd2; cfg_start_sel_i = 1;
        step(0, 0, 0);
        trig_i = 2'b01;
        step(1, 0, 0); step(1, 0, 0);
        chk("R2 wrong line does not arm", int'(count_o), 0);
        trig_i = 2'b00;
        step(0, 0, 0);
        trig_i = 2'b10;
        step(0, 0, 0);
        step(1, 0, 0); chk("R2 edge arms", int'(count_o), 1);

        // R7 reset edge on line 0
        cfg_start_i = 2'd1; cfg_reset_i = 2'd2; cfg_reset_sel_i = 0;
        step(0, 0, 0); step(0, 0, 0);
        for (int k = 0; k < 3; k++) step(1, 0, 0);
        chk("R7 before edge", int'(count_o), 3);
        trig_i = 2'b11;
        step(1, 0, 0); chk("R7 edge clears over event", int'(count_o), 0);
        trig_i = 2'b00;

        // R8 on equal to off: set wins; R9 on/off change does not clear
        cfg_reset_i = 2'd0; cfg_on_i = 7; cfg_off_i = 0;
        step(0, 0, 0); step(0, 0, 0);
        chk("R8 off at zero", int'(level_o), 0);
        cfg_on_i = 2; cfg_off_i = 2;
        step(1, 0, 0); chk("R9 on/off change keeps count", int'(count_o), 1);
        step(1, 0, 0);
        step(0, 0, 0); chk("R8 set wins", int'(level_o), 1);
        step(0, 0, 0); chk("R8 set wins held", int'(level_o), 1);

        // R9 maximum change clears
        cfg_max_i = 9;
        step(0, 0, 0); chk("R9 max change clears", int'(count_o), 0);

        summary();
        $finish;
    end
endmodule